// File: doc/BRIEF.md
# Edge-Programmed Multi-Channel PWM Bank

This block drives a bank of PWM outputs from one shared timebase. An 8-bit divider turns the input clock into step ticks, and an 8-bit step counter runs from zero up to a programmable limit, so every channel sees the same period. A channel has no duty-cycle register. It holds two absolute compare points: a rise point that sets the output high when the step counter reaches it, and a fall point that sets it low. Polarity is inverted by swapping the two points. A point above the period limit never matches, which gives a steady level. If both points are equal, the output toggles once per period, which gives a square wave at twice the period.

Software programs the bank through a simple byte-wide register port with word-spaced offsets. Reads return data one cycle after the read strobe. Some channels, picked by an elaboration mask, also keep a second copy of their compare points. When synchronous update is switched on, writes to those channels go into the copy, and the copy moves into the live registers only at the next period boundary. This lets a period that has already started run to its end unchanged. Every other write takes effect at once.

Top module: `edge_pwm_bank`

## Requirements
- R1: After a synchronous reset, every output, the read data and every register read back zero.
- R2: One period lasts (D+1)·(T+1) input clocks, where D is the divider value at offset 0x00 and T is the period limit at offset 0x04. The step counter counts 0..T, and each step lasts D+1 clocks.
- R3: An enabled channel goes high at the start of the step equal to its rise point and low at the start of the step equal to its fall point. With both points at or below T and unequal, the output is high for ((fall−rise) mod (T+1))·(D+1) clocks of each period.
- R4: With equal rise and fall points at or below T, the output toggles once per period, so over any two periods it is high for exactly one period.
- R5: A compare point greater than T never matches. With rise ≤ T < fall the output stays high. With fall ≤ T < rise, or both above T, a channel that was enabled from a low output stays low.
- R6: Bit i of the byte at 0x08 enables channel i (0–7), and bit i−8 of the byte at 0x0C enables channel i (8–15). A disabled channel drives its output low on the next clock.
- R7: Registers read back one cycle after the read strobe at these offsets: divider 0x00, period 0x04, enables 0x08/0x0C, rise point of channel i at 0x10+8·i, fall point at 0x14+8·i, synchronous-update bit 0 at 0xE4. An unmapped offset, or a cycle with no read, returns zero.
- R8: For a channel with its mask bit set, a compare-point write made while synchronous update is 1 goes into the copy. Reads keep returning the old live value until the next period boundary, and the new value after it.
- R9: For a channel without a copy, or while synchronous update is 0, a compare-point write is visible in the live register, and on readback, at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data, valid the cycle after bus_rd |
| pwm_out | output | NUM_CH | One registered PWM output per channel |

## Verification
A wrong step counter or divider changes the high time of every enabled channel within one period. The sweep over every rise/fall pair at small divider and period settings therefore compares the measured high-clock count against the arithmetic value for each pair. A wrong match decision, such as mishandled equal points or an out-of-range point that still matches, shows up as a high count that is off by whole steps, or as a 0/100% level that is wrong, within two periods. A copy register that commits too early or too late shows up on the read port: the readback taken right after a period boundary must still show the old value, and the readback taken one period later must show the new one.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int OFS_DIVIDER   = 'h00;
  localparam int OFS_LIMIT     = 'h04;
  localparam int OFS_EN_LO     = 'h08;
  localparam int OFS_EN_HI     = 'h0C;
  localparam int OFS_EDGE_BASE = 'h10;
  localparam int EDGE_STRIDE   = 8;
  localparam int OFS_FALL_ADD  = 4;
  localparam int OFS_SYNC      = 'hE4;
  localparam int EN_GROUP      = 8;
  localparam int MAX_CH        = 16;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] divider,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] step,
  output logic          eval_stb,
  output logic          wrap
);
  logic [CW-1:0] pre_q;
  logic          tick;

  assign tick     = (pre_q >= divider);
  assign wrap     = tick && (step >= limit);
  assign eval_stb = (pre_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      step  <= '0;
    end else if (tick) begin
      pre_q <= '0;
      step  <= (step >= limit) ? '0 : step + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (step == '0) && eval_stb); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (tick && !wrap) |=> (step == $past(step) + 1'b1)); // R2
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(step)); // R2
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int W          = 8,
  parameter bit HAS_SHADOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sync_on,
  input  logic [W-1:0] step,
  input  logic         eval_stb,
  input  logic         wrap,
  input  logic         wr_rise,
  input  logic         wr_fall,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rise_act,
  output logic [W-1:0] fall_act,
  output logic         pwm
);
  logic hit_r, hit_f;
  assign hit_r = (step == rise_act);
  assign hit_f = (step == fall_act);

  generate
    if (HAS_SHADOW) begin : g_shadow
      logic [W-1:0] rise_sh, fall_sh;
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_sh  <= '0;
          fall_sh  <= '0;
          rise_act <= '0;
          fall_act <= '0;
        end else begin
          if (wr_rise) rise_sh <= wdata;
          if (wr_fall) fall_sh <= wdata;
          if (wr_rise && !sync_on)  rise_act <= wdata;
          else if (wrap && sync_on) rise_act <= rise_sh;
          if (wr_fall && !sync_on)  fall_act <= wdata;
          else if (wrap && sync_on) fall_act <= fall_sh;
        end
      end

      AST_SHADOW_DEFER: assert property (@(posedge clk) disable iff (rst)
        (sync_on && !wrap) |=> ($stable(rise_act) && $stable(fall_act))); // R8
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_act <= '0;
          fall_act <= '0;
        end else begin
          if (wr_rise) rise_act <= wdata;
          if (wr_fall) fall_act <= wdata;
        end
      end

      AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_rise |=> (rise_act == $past(wdata))); // R9
      AST_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (wrap && sync_on && !wr_rise && !wr_fall) |=>
          ($stable(rise_act) && $stable(fall_act))); // R9
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pwm <= 1'b0;
    end else if (eval_stb) begin
      if (hit_r && hit_f) pwm <= ~pwm;
      else if (hit_r)     pwm <= 1'b1;
      else if (hit_f)     pwm <= 1'b0;
    end
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm); // R6
  AST_RISE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (en && eval_stb && hit_r && !hit_f) |=> pwm); // R3
  AST_FALL_MATCH: assert property (@(posedge clk) disable iff (rst)
    (en && eval_stb && hit_f && !hit_r) |=> !pwm); // R3
  AST_EQUAL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (en && eval_stb && hit_r && hit_f) |=> (pwm != $past(pwm))); // R4
  AST_NO_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !(eval_stb && (hit_r || hit_f))) |=> $stable(pwm)); // R5
endmodule

// File: rtl/edge_pwm_bank.sv
module edge_pwm_bank #(
  parameter int          NUM_CH      = 16,
  parameter int          AW          = 8,
  parameter int          DW          = 8,
  parameter logic [15:0] SHADOW_MASK = 16'h00F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  import pwm_bank_pkg::*;

  localparam int EN_W = 2 * EN_GROUP;

  logic [DW-1:0]   divider_q, limit_q;
  logic [EN_W-1:0] en_q;
  logic            sync_q;
  logic [DW-1:0]   step;
  logic            eval_stb, wrap;
  logic [DW-1:0]   rise_act [NUM_CH];
  logic [DW-1:0]   fall_act [NUM_CH];
  logic [DW-1:0]   rd_mux;
  int              addr_i;

  assign addr_i = int'(bus_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      divider_q <= '0;
      limit_q   <= '0;
      en_q      <= '0;
      sync_q    <= 1'b0;
    end else if (bus_wr) begin
      if (addr_i == OFS_DIVIDER) divider_q <= bus_wdata;
      if (addr_i == OFS_LIMIT)   limit_q   <= bus_wdata;
      if (addr_i == OFS_EN_LO)   en_q[EN_GROUP-1:0]    <= bus_wdata[EN_GROUP-1:0];
      if (addr_i == OFS_EN_HI)   en_q[EN_W-1:EN_GROUP] <= bus_wdata[EN_GROUP-1:0];
      if (addr_i == OFS_SYNC)    sync_q    <= bus_wdata[0];
    end
  end

  pwm_timebase #(.CW(DW)) u_timebase (
    .clk      (clk),
    .rst      (rst),
    .divider  (divider_q),
    .limit    (limit_q),
    .step     (step),
    .eval_stb (eval_stb),
    .wrap     (wrap)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic wr_r, wr_f;
      assign wr_r = bus_wr && (addr_i == OFS_EDGE_BASE + EDGE_STRIDE * i);
      assign wr_f = bus_wr && (addr_i == OFS_EDGE_BASE + EDGE_STRIDE * i + OFS_FALL_ADD);

      pwm_channel #(.W(DW), .HAS_SHADOW(SHADOW_MASK[i])) u_ch (
        .clk      (clk),
        .rst      (rst),
        .en       (en_q[i]),
        .sync_on  (sync_q),
        .step     (step),
        .eval_stb (eval_stb),
        .wrap     (wrap),
        .wr_rise  (wr_r),
        .wr_fall  (wr_f),
        .wdata    (bus_wdata),
        .rise_act (rise_act[i]),
        .fall_act (fall_act[i]),
        .pwm      (pwm_out[i])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (addr_i == OFS_DIVIDER) rd_mux = divider_q;
    if (addr_i == OFS_LIMIT)   rd_mux = limit_q;
    if (addr_i == OFS_EN_LO)   rd_mux = DW'(en_q[EN_GROUP-1:0]);
    if (addr_i == OFS_EN_HI)   rd_mux = DW'(en_q[EN_W-1:EN_GROUP]);
    if (addr_i == OFS_SYNC)    rd_mux = DW'(sync_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == OFS_EDGE_BASE + EDGE_STRIDE * i)                rd_mux = rise_act[i];
      if (addr_i == OFS_EDGE_BASE + EDGE_STRIDE * i + OFS_FALL_ADD) rd_mux = fall_act[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0)); // R7
  AST_SYNC_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && addr_i == OFS_SYNC) |=> (bus_rdata == DW'(sync_q))); // R7
endmodule

// File: tb/edge_pwm_bank_tb.sv
`timescale 1ns/1ps
module edge_pwm_bank_tb;
  localparam int NCH = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]     bus_addr = '0, bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic [NCH-1:0] pwm_out;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  edge_pwm_bank #(.NUM_CH(NCH), .AW(8), .DW(8), .SHADOW_MASK(16'h00F0)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic count_high(input int ch, input int win, output int n);
    n = 0;
    repeat (win) begin
      @(negedge clk);
      if (pwm_out[ch]) n++;
    end
  endtask

  function automatic int rise_ofs(input int ch); return 'h10 + 8 * ch; endfunction
  function automatic int fall_ofs(input int ch); return 'h14 + 8 * ch; endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int v, hi, len, ex, rises;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 outputs", int'(pwm_out), 0);
    rd('h00, v); chk("R1 divider", v, 0);
    rd('h04, v); chk("R1 period", v, 0);
    rd('h08, v); chk("R1 en_lo", v, 0);
    rd('h0C, v); chk("R1 en_hi", v, 0);
    rd('hE4, v); chk("R1 sync", v, 0);
    rd(rise_ofs(0), v); chk("R1 rise0", v, 0);
    rd(fall_ofs(15), v); chk("R1 fall15", v, 0);

    // R7: readback and unmapped offsets
    wr('h00, 'h5A); rd('h00, v); chk("R7 divider readback", v, 'h5A);
    wr(fall_ofs(15), 'hC3); rd(fall_ofs(15), v); chk("R7 fall15 readback", v, 'hC3);
    rd('hF0, v); chk("R7 unmapped", v, 0);
    wr('hE4, 1); rd('hE4, v); chk("R7 sync readback", v, 1);
    wr('hE4, 0);

    // R3/R4/R5: sweep every point pair on channel 0
    for (int p = 0; p < 2; p++) begin
      for (int t = 3; t < 5; t++) begin
        wr('h00, p); wr('h04, t);
        len = (p + 1) * (t + 1);
        for (int a = 0; a <= t + 1; a++) begin
          for (int b = 0; b <= t + 1; b++) begin
            wr('h08, 0);
            wr(rise_ofs(0), a); wr(fall_ofs(0), b);
            wr('h08, 1);
            repeat (2 * len + 4) @(negedge clk);
            count_high(0, 2 * len, hi);
            if (a <= t && b <= t) begin
              if (a == b) begin
                ex = len;
                chk("R4 equal points", hi, ex);
              end else begin
                ex = 2 * (((b - a) + (t + 1)) % (t + 1)) * (p + 1);
                chk("R3 high time", hi, ex);
              end
            end else begin
              ex = (a <= t) ? 2 * len : 0;
              chk("R5 out-of-range point", hi, ex);
            end
          end
        end
      end
    end

    // R2: period length by counting rising edges
    wr('h08, 0);
    wr('h00, 2); wr('h04, 6);
    wr(rise_ofs(0), 0); wr(fall_ofs(0), 1);
    wr('h08, 1);
    len = 3 * 7;
    repeat (2 * len) @(negedge clk);
    rises = 0; prev = pwm_out[0];
    repeat (3 * len) begin
      @(negedge clk);
      if (pwm_out[0] && !prev) rises++;
      prev = pwm_out[0];
    end
    chk("R2 rises in three periods", rises, 3);
    count_high(0, len, hi);
    chk("R2 one-step high time", hi, 3);

    // R6: enable mapping and disable forcing low
    wr(rise_ofs(9), 0); wr(fall_ofs(9), 7);
    wr(rise_ofs(1), 0); wr(fall_ofs(1), 7);
    wr('h0C, 'h02);
    repeat (2 * len) @(negedge clk);
    chk("R6 ch9 via upper byte", int'(pwm_out[9]), 1);
    chk("R6 ch1 not enabled", int'(pwm_out[1]), 0);
    wr('h0C, 0);
    @(negedge clk);
    chk("R6 ch9 disabled low", int'(pwm_out[9]), 0);
    wr('h08, 0);
    @(negedge clk);
    chk("R6 ch0 disabled low", int'(pwm_out[0]), 0);

    // R8/R9: copy registers
    wr('h00, 3); wr('h04, 15);
    wr(rise_ofs(0), 0); wr(fall_ofs(0), 1);
    wr('h08, 1);
    wr(rise_ofs(4), 1);
    rd(rise_ofs(4), v); chk("R9 sync off immediate", v, 1);
    wr('hE4, 1);
    prev = pwm_out[0];
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (pwm_out[0] && !prev) break;
      prev = pwm_out[0];
    end
    wr(rise_ofs(4), 9);
    rd(rise_ofs(4), v); chk("R8 old value before boundary", v, 1);
    wr(rise_ofs(1), 7);
    rd(rise_ofs(1), v); chk("R9 no-copy channel immediate", v, 7);
    repeat (70) @(negedge clk);
    rd(rise_ofs(4), v); chk("R8 new value after boundary", v, 9);
    wr('hE4, 0);
    wr(fall_ofs(5), 4);
    rd(fall_ofs(5), v); chk("R9 copy channel with sync off", v, 4);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule